// File: doc/BRIEF.md
# Up/Down Timer Counter with Slave Control

The block is a programmable timer counter that steps through 0 to a reload limit. An edge-aligned mode counts in one fixed direction. A center-aligned mode rises to the limit and then falls back to zero. Its count clock comes from a prescaler that divides the enabled count source by a programmable ratio. The reload limit and the prescaler ratio are held in shadow registers, and those are refreshed on an update event.

An update event happens on a counter wrap, on a software update strobe, or on a slave reset. It can reload the shadows, stop a one-pulse run, and raise an update pulse and a sticky update flag. A slave controller ties the counter to a trigger input in one of four ways:
- a rising trigger edge restarts the counter,
- the trigger level gates counting,
- a rising trigger edge starts counting,
- each rising trigger edge is one count clock.

The control fields and write strobes appear as plain ports. They stand in for one register bank of a larger peripheral.

Top module: `tmr_updown`

## Requirements
- R1: After reset the count is 0, the update pulse and update flag are 0, the counter is stopped, the reload limit is all ones and the prescaler ratio is 0.
- R2: In edge mode (alignMode=0) with dirDown=0, each count clock adds one. A count clock at or above the limit loads 0 instead and gives a one-cycle updPulse plus updFlag=1. The flag stays set until a flagClr strobe; set wins over clear.
- R3: In edge mode with dirDown=1, each count clock subtracts one. At 0 the count reloads the limit and gives an update. countDown reads 1.
- R4: In center modes (alignMode 1, 2 or 3, all counting alike), the count rises to the limit and then falls. At the limit it steps to limit-1 with an update. At 0 it steps to 1 with an update. countDown is 1 while falling.
- R5: With prescaler ratio P, the counter steps once every P+1 enabled count-source cycles. A pscWr value takes effect only at the next update event.
- R6: With reloadPreload=1, a reloadWr value takes effect only after the next update event. With reloadPreload=0 it applies from the cycle after the write.
- R7: With onePulse=1, the enable clears at the update event, so the counter halts at the wrapped value.
- R8: With updDisable=1, a wrap gives no updPulse, no flag and no shadow reload, but the counter still wraps.
- R9: A swUpdate strobe restarts the counter and the prescaler. The count goes to 0, or to the limit when counting down in edge mode. The strobe also gives an update event.
- R10: With updSrcOvfOnly=1, only a counter wrap raises updPulse and updFlag. A swUpdate still restarts the counter, but it raises neither.
- R11: With slaveMode=1, a rising edge on trgIn restarts the counter and gives an update, whether or not counting is enabled.
- R12: With slaveMode=2, an enabled counter steps only while trgIn is 1 and holds while trgIn is 0.
- R13: With slaveMode=3, a rising edge on trgIn sets the enable without changing the count. Counting starts the following cycle.
- R14: With slaveMode=4, an enabled counter steps only in cycles in which trgIn rises (it is 1 now and was 0 in the previous cycle). A high level held on trgIn adds no further steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enSet | input | 1 | Strobe: set counter enable |
| enClr | input | 1 | Strobe: clear counter enable |
| dirDown | input | 1 | Edge-mode direction, 1 = down |
| alignMode | input | 2 | 0 edge, 1..3 center-aligned |
| onePulse | input | 1 | Stop at the next update event |
| updDisable | input | 1 | Suppress update events |
| updSrcOvfOnly | input | 1 | Flag and pulse only on wraps |
| reloadPreload | input | 1 | Buffer reload writes until update |
| reloadWr | input | 1 | Strobe: write reload limit |
| reloadData | input | CNT_W | Reload limit value |
| pscWr | input | 1 | Strobe: write prescaler ratio |
| pscData | input | PSC_W | Prescaler ratio value |
| swUpdate | input | 1 | Strobe: software update and restart |
| slaveMode | input | 3 | 0 off, 1 reset, 2 gated, 3 trigger, 4 external clock |
| trgIn | input | 1 | Trigger input, synchronous to clk |
| flagClr | input | 1 | Strobe: clear update flag |
| count | output | CNT_W | Current count |
| countDown | output | 1 | Current counting direction, 1 = down |
| updPulse | output | 1 | One-cycle update request |
| updFlag | output | 1 | Sticky update flag |

## Verification
The hardest cases to reach from the ports are those in which two effects fall on the same clock edge. One is a shadowed reload value arriving at the same edge as a wrap. Another is a one-pulse stop landing on the wrap that produces it. A third is an enable clear that still lets one more count clock through. The stimulus first drives the counter to a known value with a software update, then times each write strobe against a hand-computed count sequence. This way the preloaded limit, the prescaler ratio and the one-pulse stop are each seen to take effect exactly one period later or exactly at the wrap. The slave modes are reached by holding the enable and toggling trgIn level by level, so edge-driven and level-driven counting can be told apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SlaveSelW = 3;
  localparam logic [SlaveSelW-1:0] SlvReset  = 3'd1;
  localparam logic [SlaveSelW-1:0] SlvGate   = 3'd2;
  localparam logic [SlaveSelW-1:0] SlvTrig   = 3'd3;
  localparam logic [SlaveSelW-1:0] SlvExtClk = 3'd4;

  typedef struct packed {
    logic tick;        // advance the counter by one step
    logic reinit;      // restart the counter
    logic loadShadow;  // update event: copy preload values into shadows
  } dpStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enSet,
  input  logic                 enClr,
  input  logic                 onePulse,
  input  logic                 updDisable,
  input  logic                 updSrcOvfOnly,
  input  logic                 pscWr,
  input  logic [PSC_W-1:0]     pscData,
  input  logic                 swUpdate,
  input  logic [SlaveSelW-1:0] slaveMode,
  input  logic                 trgIn,
  input  logic                 flagClr,
  input  logic                 wrapNow,
  output dpStrobe_t            strb,
  output logic                 updPulse,
  output logic                 updFlag
);
  logic en, trgPrev, trgRise;
  logic isReset, isGate, isTrig, isExt;
  logic slvRst, trigStart, countSrc, reinit, pscDone, tick, uev, reqEvt;
  logic [PSC_W-1:0] pscCnt, pscReg, pscShadow;

  assign isReset   = (slaveMode == SlvReset);
  assign isGate    = (slaveMode == SlvGate);
  assign isTrig    = (slaveMode == SlvTrig);
  assign isExt     = (slaveMode == SlvExtClk);
  assign trgRise   = trgIn & ~trgPrev;
  assign slvRst    = isReset & trgRise;
  assign trigStart = isTrig & trgRise;

  // count source: enable, qualified by gate level or external edge
  assign countSrc = en & (isGate ? trgIn : 1'b1) & (isExt ? trgRise : 1'b1);
  assign reinit   = swUpdate | slvRst;
  assign pscDone  = (pscCnt >= pscShadow);
  assign tick     = countSrc & pscDone & ~reinit;
  assign uev      = ~updDisable & (wrapNow | reinit);
  assign reqEvt   = ~updDisable & (updSrcOvfOnly ? wrapNow : (wrapNow | reinit));

  assign strb = '{tick: tick, reinit: reinit, loadShadow: uev};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en        <= 1'b0;
      trgPrev   <= 1'b0;
      pscCnt    <= '0;
      pscReg    <= '0;
      pscShadow <= '0;
      updPulse  <= 1'b0;
      updFlag   <= 1'b0;
    end else begin
      trgPrev <= trgIn;
      if (reinit)        pscCnt <= '0;
      else if (countSrc) pscCnt <= pscDone ? '0 : pscCnt + 1'b1;
      if (pscWr) pscReg    <= pscData;
      if (uev)   pscShadow <= pscReg;
      if (enClr)                    en <= 1'b0;
      else if (enSet || trigStart)  en <= 1'b1;
      else if (onePulse && uev)     en <= 1'b0;
      updPulse <= reqEvt;
      if (reqEvt)       updFlag <= 1'b1;
      else if (flagClr) updFlag <= 1'b0;
    end
  end

  assert_udis_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    updDisable |=> !updPulse);
  assert_src_filter_R10: assert property (@(posedge clk) disable iff (!rstN)
    (updSrcOvfOnly && !wrapNow) |=> !updPulse);
  assert_onepulse_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (onePulse && uev && !enSet && !trigStart) |=> !en);
  assert_gate_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (isGate && !trgIn) |-> !strb.tick);
  assert_extclk_edge_R14: assert property (@(posedge clk) disable iff (!rstN)
    (isExt && !trgRise) |-> !strb.tick);
  assert_pulse_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> updFlag);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic             dirDown,
  input  logic [1:0]       alignMode,
  input  logic             reloadPreload,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadData,
  output logic [CNT_W-1:0] count,
  output logic             countDown,
  output logic             wrapNow
);
  logic [CNT_W-1:0] cnt, arrReg, arrShadow, arrEff, reloadNext;
  logic dirState, center, goDown, atLimit;

  assign center     = (alignMode != 2'd0);
  assign goDown     = center ? dirState : dirDown;
  assign arrEff     = reloadPreload ? arrShadow : arrReg;
  assign reloadNext = strb.loadShadow ? arrReg : arrEff;
  assign atLimit    = goDown ? (cnt == '0) : (cnt >= arrEff);
  assign wrapNow    = strb.tick & atLimit;
  assign count      = cnt;
  assign countDown  = goDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      arrReg    <= RELOAD_RST;
      arrShadow <= RELOAD_RST;
      dirState  <= 1'b0;
    end else begin
      if (reloadWr)        arrReg    <= reloadData;
      if (strb.loadShadow) arrShadow <= arrReg;
      if (strb.reinit) begin
        cnt      <= (!center && dirDown) ? reloadNext : '0;
        dirState <= 1'b0;
      end else if (strb.tick) begin
        if (!center) begin
          if (dirDown) cnt <= atLimit ? reloadNext : cnt - 1'b1;
          else         cnt <= atLimit ? '0 : cnt + 1'b1;
        end else if (!dirState) begin
          if (atLimit) begin
            cnt      <= (reloadNext == '0) ? '0 : reloadNext - 1'b1;
            dirState <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end else begin
          if (atLimit) begin
            cnt      <= (reloadNext == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
            dirState <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_count_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.tick || strb.reinit) |=> $stable(count));
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter int               PSC_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             dirDown,
  input  logic [1:0]       alignMode,
  input  logic             onePulse,
  input  logic             updDisable,
  input  logic             updSrcOvfOnly,
  input  logic             reloadPreload,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] reloadData,
  input  logic             pscWr,
  input  logic [PSC_W-1:0] pscData,
  input  logic             swUpdate,
  input  logic [2:0]       slaveMode,
  input  logic             trgIn,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             countDown,
  output logic             updPulse,
  output logic             updFlag
);
  dpStrobe_t strb;
  logic wrapNow;

  tmr_ctrl #(.PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr), .onePulse(onePulse),
    .updDisable(updDisable), .updSrcOvfOnly(updSrcOvfOnly), .pscWr(pscWr),
    .pscData(pscData), .swUpdate(swUpdate), .slaveMode(slaveMode), .trgIn(trgIn),
    .flagClr(flagClr), .wrapNow(wrapNow), .strb(strb), .updPulse(updPulse),
    .updFlag(updFlag)
  );

  tmr_datapath #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dirDown(dirDown), .alignMode(alignMode),
    .reloadPreload(reloadPreload), .reloadWr(reloadWr), .reloadData(reloadData),
    .count(count), .countDown(countDown), .wrapNow(wrapNow)
  );
endmodule

// File: tb/tmr_updown_tb.sv
module tmr_updown_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enSet = 0, enClr = 0, dirDown = 0, onePulse = 0, updDisable = 0;
  logic updSrcOvfOnly = 0, reloadPreload = 0, reloadWr = 0, pscWr = 0;
  logic swUpdate = 0, trgIn = 0, flagClr = 0;
  logic [1:0] alignMode = 2'd0;
  logic [2:0] slaveMode = 3'd0;
  logic [CNT_W-1:0] reloadData = '0;
  logic [PSC_W-1:0] pscData = '0;
  logic [CNT_W-1:0] count;
  logic countDown, updPulse, updFlag;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  typedef struct {
    int cnt; int pulse; int flag; int dn; string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_updown #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rstN(rstN), .enSet(enSet), .enClr(enClr), .dirDown(dirDown),
    .alignMode(alignMode), .onePulse(onePulse), .updDisable(updDisable),
    .updSrcOvfOnly(updSrcOvfOnly), .reloadPreload(reloadPreload),
    .reloadWr(reloadWr), .reloadData(reloadData), .pscWr(pscWr), .pscData(pscData),
    .swUpdate(swUpdate), .slaveMode(slaveMode), .trgIn(trgIn), .flagClr(flagClr),
    .count(count), .countDown(countDown), .updPulse(updPulse), .updFlag(updFlag)
  );

  task automatic cmpOne(string tag, string what, int act, int ex);
    if (ex < 0) return;
    nCmp++;
    if (act != ex) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, ex);
    end
  endtask

  // monitor: consumes the item pushed for the edge just passed
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmpOne(e.tag, "count", int'(count), e.cnt);
      cmpOne(e.tag, "updPulse", int'(updPulse), e.pulse);
      cmpOne(e.tag, "updFlag", int'(updFlag), e.flag);
      cmpOne(e.tag, "countDown", int'(countDown), e.dn);
    end
  end

  // driver: inputs set before the call apply for one clock; expectation is
  // for the outputs after that clock edge
  task automatic step(int c, int p, int f, int d, string tag);
    exp_t e;
    if (tag != "") begin
      e.cnt = c; e.pulse = p; e.flag = f; e.dn = d; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk); #1;
    enSet = 0; enClr = 0; reloadWr = 0; pscWr = 0; swUpdate = 0; flagClr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(-1, -1, -1, -1, "");
  endtask

  task automatic seq(int first, int last, string tag);
    for (int v = first; v <= last; v++) step(v, 0, -1, -1, tag);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R1: reset state, counter stopped
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");

    // R2: edge up, limit 3
    reloadWr = 1; reloadData = 3; step(0, 0, 0, -1, "R2");
    enSet = 1; step(0, 0, 0, 0, "R2");
    seq(1, 3, "R2");
    step(0, 1, 1, 0, "R2");
    step(1, 0, 1, 0, "R2");
    flagClr = 1; step(2, 0, 0, 0, "R2");
    enClr = 1; step(3, 0, 0, -1, "R2");
    step(3, 0, 0, -1, "R2");
    // R9: software update restarts up-counter
    swUpdate = 1; step(0, 1, 1, -1, "R9");
    flagClr = 1; step(0, 0, 0, -1, "R9");

    // R3: edge down
    dirDown = 1; enSet = 1; step(0, 0, 0, 1, "R3");
    step(3, 1, 1, 1, "R3");
    step(2, 0, -1, 1, "R3");
    step(1, 0, -1, 1, "R3");
    step(0, 0, -1, 1, "R3");
    step(3, 1, 1, 1, "R3");
    flagClr = 1; enClr = 1; step(2, 0, 0, 1, "R3");
    swUpdate = 1; step(3, 1, 1, 1, "R9");
    flagClr = 1; step(3, 0, 0, 1, "R9");

    // R4: center-aligned, mode 1 then mode 3
    dirDown = 0; alignMode = 2'd1;
    swUpdate = 1; step(0, 1, -1, 0, "R4");
    enSet = 1; step(0, 0, -1, 0, "R4");
    step(1, 0, -1, 0, "R4"); step(2, 0, -1, 0, "R4"); step(3, 0, -1, 0, "R4");
    step(2, 1, -1, 1, "R4"); step(1, 0, -1, 1, "R4"); step(0, 0, -1, 1, "R4");
    step(1, 1, -1, 0, "R4"); step(2, 0, -1, 0, "R4");
    enClr = 1; idle(1);
    alignMode = 2'd3; swUpdate = 1; idle(1);
    enSet = 1; step(0, 0, -1, 0, "R4");
    seq(1, 3, "R4");
    step(2, 1, -1, 1, "R4");
    enClr = 1; idle(1);
    alignMode = 2'd0; flagClr = 1; idle(1);

    // R5: prescaler ratio applies only after an update
    swUpdate = 1; idle(1);
    enSet = 1; step(0, 0, -1, -1, "R5");
    pscWr = 1; pscData = 2; step(1, 0, -1, -1, "R5");
    step(2, 0, -1, -1, "R5");
    swUpdate = 1; step(0, 1, -1, -1, "R5");
    step(0, 0, -1, -1, "R5"); step(0, 0, -1, -1, "R5"); step(1, 0, -1, -1, "R5");
    step(1, 0, -1, -1, "R5"); step(1, 0, -1, -1, "R5"); step(2, 0, -1, -1, "R5");
    enClr = 1; pscWr = 1; pscData = 0; idle(1);
    swUpdate = 1; idle(1);
    flagClr = 1; idle(1);

    // R6: preloaded reload, then immediate reload
    reloadPreload = 1; swUpdate = 1; idle(1);
    reloadWr = 1; reloadData = 5; step(0, -1, -1, -1, "R6");
    enSet = 1; step(0, -1, -1, -1, "R6");
    seq(1, 3, "R6");
    step(0, 1, -1, -1, "R6");
    seq(1, 5, "R6");
    step(0, 1, -1, -1, "R6");
    reloadPreload = 0; step(1, 0, -1, -1, "R6");
    reloadWr = 1; reloadData = 2; step(2, 0, -1, -1, "R6");
    step(0, 1, -1, -1, "R6");
    enClr = 1; idle(1);
    flagClr = 1; idle(1);

    // R7: one-pulse
    onePulse = 1; swUpdate = 1; idle(1);
    enSet = 1; step(0, -1, -1, -1, "R7");
    seq(1, 2, "R7");
    step(0, 1, -1, -1, "R7");
    step(0, 0, -1, -1, "R7");
    step(0, 0, -1, -1, "R7");
    onePulse = 0; flagClr = 1; idle(1);

    // R8: update disable
    reloadPreload = 1; swUpdate = 1; idle(1);
    flagClr = 1; idle(1);
    updDisable = 1; reloadWr = 1; reloadData = 4; step(0, 0, 0, -1, "R8");
    enSet = 1; step(0, 0, 0, -1, "R8");
    step(1, 0, 0, -1, "R8"); step(2, 0, 0, -1, "R8"); step(0, 0, 0, -1, "R8");
    step(1, 0, 0, -1, "R8"); step(2, 0, 0, -1, "R8"); step(0, 0, 0, -1, "R8");
    enClr = 1; idle(1);
    updDisable = 0; reloadPreload = 0;

    // R10: update source restricted to wraps
    updSrcOvfOnly = 1; swUpdate = 1; step(0, 0, 0, -1, "R10");
    enSet = 1; step(0, 0, 0, -1, "R10");
    seq(1, 4, "R10");
    step(0, 1, 1, -1, "R10");
    flagClr = 1; enClr = 1; idle(1);
    updSrcOvfOnly = 0;

    // R11: slave reset
    slaveMode = 3'd1; swUpdate = 1; idle(1);
    flagClr = 1; idle(1);
    enSet = 1; idle(1);
    step(1, 0, 0, -1, "R11"); step(2, 0, 0, -1, "R11");
    trgIn = 1; step(0, 1, 1, -1, "R11");
    step(1, 0, 1, -1, "R11");
    trgIn = 0; idle(1);
    flagClr = 1; idle(1);

    // R12: gated
    slaveMode = 3'd2; swUpdate = 1; idle(1);
    step(0, -1, -1, -1, "R12"); step(0, -1, -1, -1, "R12");
    trgIn = 1; step(1, -1, -1, -1, "R12"); step(2, -1, -1, -1, "R12");
    trgIn = 0; step(2, -1, -1, -1, "R12"); step(2, -1, -1, -1, "R12");

    // R13: trigger start without reset
    enClr = 1; slaveMode = 3'd3; step(3, -1, -1, -1, "R13");
    step(3, -1, -1, -1, "R13");
    trgIn = 1; step(3, -1, -1, -1, "R13");
    step(4, -1, -1, -1, "R13");
    step(0, 1, -1, -1, "R13");

    // R14: external clock on trigger edges
    trgIn = 0; slaveMode = 3'd4; swUpdate = 1; idle(1);
    step(0, -1, -1, -1, "R14");
    trgIn = 1; step(1, -1, -1, -1, "R14");
    step(1, -1, -1, -1, "R14");
    trgIn = 0; step(1, -1, -1, -1, "R14");
    trgIn = 1; step(2, -1, -1, -1, "R14");
    idle(2);

    done = 1;
    report();
    $finish;
  end
endmodule